// File: doc/BRIEF.md
# Slow-to-Fast Word Sampler Driven by a Toggle Strobe

This block carries a multi-bit word from a slow clock domain into a much faster, unrelated clock domain. It does this once per slow period, with no handshake and no FIFO. On every slow rising edge, the slow side does two things: it registers the incoming word into a holding register, and it inverts a single toggle flip-flop. Only that one toggle bit crosses through a chain of fast-domain synchronizer stages. A history register sits behind the chain and is compared with it by XOR. The result is a strobe that lasts exactly one fast cycle, a fixed number of fast edges after the slow edge.

When the strobe is high, the fast side loads the whole held word in parallel, with no synchronizer on any data bit. This is safe because the held word changed only at the slow edge and stays put until the next one. A valid flag is registered in the same fast edge as the word. The consumer therefore sees `fast_valid` high for one cycle together with the new `fast_data`. The scheme depends on the slow period being much longer than the synchronizer latency plus two fast cycles.

Resets are synchronous and active low, one per domain. No asynchronous clears are used anywhere.

Top module: `tsync_sampler`

## Requirements
- R1: The slow-side toggle inverts on every slow rising edge taken out of reset, so each such edge produces exactly one capture in the fast domain, even if the word did not change.
- R2: The fast-domain strobe is high for exactly one fast cycle per slow period and is never high in two consecutive fast cycles.
- R3: With SYNC_STAGES = N (default 3), the capture happens at the (N+1)-th fast rising edge after a slow rising edge. `fast_valid` is high during the fast cycle that follows that edge, which is N+2 fast edges of latency counted to the first edge where `fast_valid` reads high.
- R4: The word on `fast_data` after a capture equals `slow_data` as sampled at the slow rising edge that caused the capture. All W bits (default 16) are loaded together.
- R5: Between captures, `fast_data` holds its value unchanged.
- R6: While `fast_rst_n` is low, `fast_valid` and `fast_data` read zero after the next fast edge. While `slow_rst_n` is low, no toggle happens, so no strobe appears until the first slow edge after release.
- R7: `fast_valid` is a single-cycle pulse that is registered alongside the data and is never high in two consecutive fast cycles.
- R8: Repeated identical words, including all-zeros and all-ones, still each produce their own `fast_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow-domain clock |
| slow_rst_n | input | 1 | Slow-domain synchronous reset, active low |
| slow_data | input | W | Word to be carried, sampled on slow rising edges |
| fast_clk | input | 1 | Fast-domain clock, unrelated to slow_clk |
| fast_rst_n | input | 1 | Fast-domain synchronous reset, active low |
| fast_data | output | W | Captured word, held between captures |
| fast_valid | output | 1 | One-cycle pulse marking a newly captured word |

## Verification
The word sequence covers three kinds of stimulus, each aimed at a different fault:
- All-zeros and all-ones words, given twice in a row, show that a capture fires on every slow edge whether or not the data changed, which separates the unconditional toggle from any change detector.
- A walking one and alternating-bit words expose a swapped, dropped or stuck bit lane in the parallel load.
- A long pseudo-random run, compared on every fast cycle against a behavioural model that ages each slow event by counted fast edges, pins the exact capture latency and shows that the output holds between captures.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  // Number of fast rising edges from a slow rising edge to the edge that
  // loads the captured word: one per synchronizer stage plus the history
  // register edge on which the strobe is consumed.
  function automatic int capture_edge_count(input int stages);
    return stages + 1;
  endfunction

  // Clamp the synchronizer depth to a sane minimum.
  function automatic int legal_stages(input int requested);
    return (requested < 2) ? 2 : requested;
  endfunction

  typedef enum logic [0:0] {
    PHASE_EVEN = 1'b0,
    PHASE_ODD  = 1'b1
  } toggle_phase_e;

endpackage

// File: rtl/tsync_toggle_src.sv
module tsync_toggle_src #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  output logic         toggle_q,
  output logic [W-1:0] word_q
);
  import tsync_pkg::*;

  toggle_phase_e phase_q;

  // The phase flips unconditionally on every slow edge out of reset.
  // The word register is loaded on the same edge, so the word and the
  // toggle always change together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PHASE_EVEN;
      word_q  <= '0;
    end else begin
      phase_q <= (phase_q == PHASE_EVEN) ? PHASE_ODD : PHASE_EVEN;
      word_q  <= data_in;
    end
  end

  assign toggle_q = (phase_q == PHASE_ODD);

endmodule

// File: rtl/tsync_sync_chain.sv
module tsync_sync_chain #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/tsync_edge_strobe.sv
module tsync_edge_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic strobe
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= level_in;
  end

  // Either direction of change marks one slow edge.
  assign strobe = level_in ^ hist_q;

endmodule

// File: rtl/tsync_capture.sv
module tsync_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) word_q <= word_in;
    end
  end

endmodule

// File: rtl/tsync_sampler.sv
module tsync_sampler #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 3
) (
  input  logic         slow_clk,
  input  logic         slow_rst_n,
  input  logic [W-1:0] slow_data,
  input  logic         fast_clk,
  input  logic         fast_rst_n,
  output logic [W-1:0] fast_data,
  output logic         fast_valid
);
  import tsync_pkg::*;

  localparam int STAGES = legal_stages(SYNC_STAGES);

  // Named internal events, kept visible for the bound checker.
  logic         slow_toggle;
  logic [W-1:0] slow_word;
  logic         fast_level;
  logic         fast_strobe;

  tsync_toggle_src #(.W(W)) u_src (
    .clk      (slow_clk),
    .rst_n    (slow_rst_n),
    .data_in  (slow_data),
    .toggle_q (slow_toggle),
    .word_q   (slow_word)
  );

  tsync_sync_chain #(.STAGES(STAGES)) u_sync (
    .clk      (fast_clk),
    .rst_n    (fast_rst_n),
    .async_in (slow_toggle),
    .sync_out (fast_level)
  );

  tsync_edge_strobe u_edge (
    .clk      (fast_clk),
    .rst_n    (fast_rst_n),
    .level_in (fast_level),
    .strobe   (fast_strobe)
  );

  // The held word is stable for the whole slow period, so it is loaded
  // in parallel with no per-bit synchronizer.
  tsync_capture #(.W(W)) u_cap (
    .clk     (fast_clk),
    .rst_n   (fast_rst_n),
    .load    (fast_strobe),
    .word_in (slow_word),
    .word_q  (fast_data),
    .valid_q (fast_valid)
  );

endmodule

// File: rtl/tsync_sampler_chk.sv
module tsync_sampler_chk #(
  parameter int W = 16
) (
  input logic         fast_clk,
  input logic         fast_rst_n,
  input logic         strobe,
  input logic [W-1:0] slow_word,
  input logic [W-1:0] fast_data,
  input logic         fast_valid
);

  assert_strobe_single_R2: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    strobe |=> !strobe);

  assert_valid_after_strobe_R3: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    strobe |=> fast_valid);

  assert_no_spurious_valid_R3: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    !strobe |=> !fast_valid);

  assert_word_captured_R4: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    strobe |=> (fast_data == $past(slow_word)));

  assert_data_held_R5: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    !strobe |=> $stable(fast_data));

  assert_reset_clears_R6: assert property (
    @(posedge fast_clk)
    !fast_rst_n |=> (!fast_valid && fast_data == '0));

  assert_valid_pulse_R7: assert property (
    @(posedge fast_clk) disable iff (!fast_rst_n)
    fast_valid |=> !fast_valid);

endmodule

bind tsync_sampler tsync_sampler_chk #(.W(W)) u_chk (
  .fast_clk   (fast_clk),
  .fast_rst_n (fast_rst_n),
  .strobe     (fast_strobe),
  .slow_word  (slow_word),
  .fast_data  (fast_data),
  .fast_valid (fast_valid)
);

// File: tb/tsync_sampler_tb.sv
module tsync_sampler_tb;
  localparam int W      = 16;
  localparam int STAGES = 3;
  localparam int LAT    = STAGES + 1;  // fast edges from slow edge to capture edge

  logic         slow_clk = 1'b0;
  logic         fast_clk = 1'b0;
  logic         slow_rst_n = 1'b0;
  logic         fast_rst_n = 1'b0;
  logic [W-1:0] slow_data = '0;
  logic [W-1:0] fast_data;
  logic         fast_valid;

  int compared = 0;
  int mismatched = 0;
  int slow_events = 0;
  int valid_seen = 0;
  bit done = 1'b0;
  bit any_slow_edge = 1'b0;
  bit fast_started = 1'b0;

  tsync_sampler #(.W(W), .SYNC_STAGES(STAGES)) u_dut (
    .slow_clk   (slow_clk),
    .slow_rst_n (slow_rst_n),
    .slow_data  (slow_data),
    .fast_clk   (fast_clk),
    .fast_rst_n (fast_rst_n),
    .fast_data  (fast_data),
    .fast_valid (fast_valid)
  );

  // 50 MHz fast clock: rising edges at 10, 30, 50 ns ...
  always #10 fast_clk = ~fast_clk;

  // Slow clock, period 466 ns, rising edges at odd times (7 + 466k),
  // so they never coincide with a fast edge.
  initial begin
    #7 slow_clk = 1'b1;
    forever #233 slow_clk = ~slow_clk;
  end

  // Reference model: each slow edge out of reset becomes an event with
  // an age in fast edges and the word present at that edge.
  int           ev_age[$];
  logic [W-1:0] ev_word[$];
  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_data  = '0;

  always @(posedge slow_clk) begin
    if (slow_rst_n) begin
      ev_word.push_back(slow_data);
      ev_age.push_back(0);
      slow_events++;
      any_slow_edge = 1'b1;
    end
  end

  always @(posedge fast_clk) begin
    fast_started = 1'b1;
    if (!fast_rst_n) begin
      exp_valid = 1'b0;
      exp_data  = '0;
    end else begin
      exp_valid = 1'b0;
      foreach (ev_age[i]) ev_age[i] = ev_age[i] + 1;
      if (ev_age.size() > 0 && ev_age[0] == LAT) begin
        exp_valid = 1'b1;
        exp_data  = ev_word[0];
        void'(ev_age.pop_front());
        void'(ev_word.pop_front());
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // Compare on every fast cycle, sampled on the falling edge.
  logic prev_valid = 1'b0;
  always @(negedge fast_clk) begin
    if (fast_started && !done) begin
      if (!any_slow_edge) begin
        // R6: reset state and no strobe before the first slow edge
        check(fast_valid === 1'b0, "R6 valid idle", {{(W-1){1'b0}}, fast_valid}, '0);
        check(fast_data === '0, "R6 data zero", fast_data, '0);
      end else begin
        // R3/R1: valid exactly where the model places the capture
        check(fast_valid === exp_valid, "R3 valid timing",
              {{(W-1){1'b0}}, fast_valid}, {{(W-1){1'b0}}, exp_valid});
        // R4/R5: captured word, held between captures
        check(fast_data === exp_data,
              exp_valid ? "R4 captured word" : "R5 held word", fast_data, exp_data);
        // R7/R2: single-cycle pulse
        check(!(prev_valid && fast_valid), "R7 pulse width",
              {{(W-1){1'b0}}, fast_valid}, '0);
      end
      if (fast_valid === 1'b1) valid_seen++;
      prev_valid = fast_valid;
    end
  end

  task automatic drive_word(input logic [W-1:0] v);
    @(negedge slow_clk);
    slow_data <= v;
  endtask

  initial begin : stim
    logic [W-1:0] lfsr;
    #50 fast_rst_n = 1'b1;
    #50 slow_rst_n = 1'b1;
    // R8: repeated identical words still each produce a pulse
    drive_word('0);
    drive_word('0);
    drive_word('1);
    drive_word('1);
    drive_word({(W/2){2'b10}});
    drive_word({(W/2){2'b01}});
    for (int b = 0; b < W; b++) drive_word(W'(1) << b);
    lfsr = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive_word(lfsr);
    end
    repeat (3) @(posedge slow_clk);
    // Let the last slow edge drain through the fast side.
    repeat (LAT + 4) @(posedge fast_clk);
    @(negedge fast_clk);
    // R1/R2: one capture per slow edge, pending events excluded
    check(valid_seen == slow_events - ev_age.size(), "R1 one capture per slow edge",
          W'(valid_seen), W'(slow_events - ev_age.size()));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule